// File: doc/BRIEF.md
# Serial Channel DMA Request and Wait Generator

This block produces the handshake outputs that let a DMA controller, or the CPU, pace data through one channel of a serial controller that has a transmit FIFO and a receive FIFO. It watches the occupancy of both FIFOs and the access strobes from the CPU and the DMA engine. It drives two active-low pins. The first pin is shared: it can act as a transmit request, a receive request or a CPU wait line. The second pin can act only as a transmit request. When it is not used for DMA, it acts as a plain modem-control output.

A seven-bit configuration register holds the operating mode and is loaded with a single write strobe. For full-duplex DMA, set the first pin to receive and enable the second pin as the transmit request. The transmit pacing bit is also exported so that the transmit interrupt logic can follow the same rule.

Top module: `sdma_req_top`

## Requirements
- R1: After reset, `wreq_n` and `dtrreq_n` are 1 and `tx_mode_o` is 1. Every configuration field is 0 except the transmit pacing bit.
- R2: When `cfg_we` is 1 at a clock edge, the register takes `cfg_wdata`. The bit fields are: bit0 function enable, bit1 first-pin request mode (1 = request, 0 = wait), bit2 first-pin direction (1 = receive, 0 = transmit), bit3 second pin as transmit request, bit4 modem-control level, bit5 transmit pacing, bit6 receive threshold. `tx_mode_o` shows bit5 from the edge after the write.
- R3: With pacing 0, the transmit request is active while `tx_level` is below `TX_DEPTH`. It is never active when the FIFO is full.
- R4: With pacing 1, the transmit request is active only while `tx_level` is 0.
- R5: The receive request is active while `rx_level` is not 0. The receive threshold bit has no effect on it.
- R6: In request mode, the first pin carries the receive request when the direction bit is 1 and the transmit request when it is 0.
- R7: When bit3 is set and the function is enabled, `dtrreq_n` carries the transmit request.
- R8: In wait mode with the function enabled, `wreq_n` is low exactly when `cpu_rd_rx` is 1 and `rx_level` is 0.
- R9: A `dma_wr_tx` strobe forces the transmit request inactive on the next cycle. A `dma_rd_rx` strobe does the same for the receive request.
- R10: With the function disabled, `wreq_n` is 1. `dtrreq_n` is the inverse of the modem-control bit whenever the second pin is not serving as a transmit request.
- R11: Each pin reflects the inputs and configuration of the previous clock edge. There is exactly one register stage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 7 | Configuration write data |
| tx_level | input | TXW | Transmit FIFO occupancy |
| rx_level | input | RXW | Receive FIFO occupancy |
| cpu_rd_rx | input | 1 | CPU read of receive data in progress |
| dma_wr_tx | input | 1 | DMA write into transmit FIFO |
| dma_rd_rx | input | 1 | DMA read from receive FIFO |
| wreq_n | output | 1 | Shared wait/request pin, active low |
| dtrreq_n | output | 1 | Transmit request or modem-control pin, active low |
| tx_mode_o | output | 1 | Transmit pacing bit for the interrupt logic |

## Verification
A configuration write is seen on `tx_mode_o` one edge later. It reaches the pins only from the edge after that, because the pins are built from the stored configuration. A FIFO level or a strobe applied before an edge appears on the pins right after that edge. Inputs are driven at the falling edge. At each rising edge the reference model computes what the pins must show after that edge. The comparison is made at the following falling edge, so every expected value is aligned to the one register stage.

// File: rtl/sdma_pkg.sv
package sdma_pkg;
    localparam int CFG_W = 7;

    typedef struct packed {
        logic rx_thresh;   // bit6
        logic tx_mode;     // bit5
        logic dtr_bit;     // bit4
        logic dtr_req_en;  // bit3
        logic dir_rx;      // bit2
        logic func_req;    // bit1
        logic req_en;      // bit0
    } sdma_cfg_t;

    localparam logic [CFG_W-1:0] CFG_RST = 7'b010_0000;

    typedef struct packed {
        logic wreq_n;
        logic dtrreq_n;
    } sdma_pins_t;
endpackage

// File: rtl/sdma_cfg_reg.sv
module sdma_cfg_reg
    import sdma_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [CFG_W-1:0] wdata,
    output sdma_cfg_t        cfg_q
);
    sdma_cfg_t cfg_d;

    always_comb begin
        cfg_d = cfg_q;
        if (we) cfg_d = sdma_cfg_t'(wdata);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= sdma_cfg_t'(CFG_RST);
        else        cfg_q <= cfg_d;
    end

    AST_CFG_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> (cfg_q == sdma_cfg_t'($past(wdata)))); // R2
endmodule

// File: rtl/sdma_tx_req.sv
module sdma_tx_req #(
    parameter int DEPTH = 4,
    parameter int LW    = $clog2(DEPTH + 1)
) (
    input  logic [LW-1:0] level,
    input  logic          pace_empty,
    input  logic          wr_stb,
    output logic          want
);
    localparam logic [LW-1:0] FULL_LVL = LW'(DEPTH);
    logic room;
    logic empty;

    always_comb begin
        room  = (level < FULL_LVL);
        empty = (level == '0);
        want  = (pace_empty ? empty : room) && !wr_stb;
    end
endmodule

// File: rtl/sdma_rx_req.sv
module sdma_rx_req #(
    parameter int DEPTH = 4,
    parameter int LW    = $clog2(DEPTH + 1)
) (
    input  logic [LW-1:0] level,
    input  logic          rd_stb,
    input  logic          cpu_rd,
    output logic          req_want,
    output logic          wait_want
);
    logic has_data;

    always_comb begin
        has_data  = (level != '0);
        req_want  = has_data && !rd_stb;
        wait_want = cpu_rd && !has_data;
    end
endmodule

// File: rtl/sdma_req_top.sv
module sdma_req_top
    import sdma_pkg::*;
#(
    parameter int TX_DEPTH = 4,
    parameter int RX_DEPTH = 4,
    parameter int TXW      = $clog2(TX_DEPTH + 1),
    parameter int RXW      = $clog2(RX_DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [CFG_W-1:0] cfg_wdata,
    input  logic [TXW-1:0]   tx_level,
    input  logic [RXW-1:0]   rx_level,
    input  logic             cpu_rd_rx,
    input  logic             dma_wr_tx,
    input  logic             dma_rd_rx,
    output logic             wreq_n,
    output logic             dtrreq_n,
    output logic             tx_mode_o
);
    localparam logic [TXW-1:0] TX_FULL = TXW'(TX_DEPTH);

    sdma_cfg_t  cfg_q;
    sdma_pins_t pins_d, pins_q;
    logic       tx_want, rx_want, wait_want;

    sdma_cfg_reg u_cfg (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (cfg_we),
        .wdata (cfg_wdata),
        .cfg_q (cfg_q)
    );

    sdma_tx_req #(.DEPTH(TX_DEPTH), .LW(TXW)) u_tx (
        .level      (tx_level),
        .pace_empty (cfg_q.tx_mode),
        .wr_stb     (dma_wr_tx),
        .want       (tx_want)
    );

    sdma_rx_req #(.DEPTH(RX_DEPTH), .LW(RXW)) u_rx (
        .level     (rx_level),
        .rd_stb    (dma_rd_rx),
        .cpu_rd    (cpu_rd_rx),
        .req_want  (rx_want),
        .wait_want (wait_want)
    );

    always_comb begin
        pins_d          = '{wreq_n: 1'b1, dtrreq_n: 1'b1};
        if (cfg_q.req_en) begin
            if (cfg_q.func_req)
                pins_d.wreq_n = !(cfg_q.dir_rx ? rx_want : tx_want);
            else
                pins_d.wreq_n = !wait_want;
        end
        if (cfg_q.req_en && cfg_q.dtr_req_en)
            pins_d.dtrreq_n = !tx_want;
        else
            pins_d.dtrreq_n = !cfg_q.dtr_bit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pins_q <= '{wreq_n: 1'b1, dtrreq_n: 1'b1};
        else        pins_q <= pins_d;
    end

    assign wreq_n    = pins_q.wreq_n;
    assign dtrreq_n  = pins_q.dtrreq_n;
    assign tx_mode_o = cfg_q.tx_mode;

    AST_DISABLED_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_q.req_en |=> wreq_n); // R10
    AST_TX_FULL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_q.req_en && cfg_q.dtr_req_en && tx_level == TX_FULL) |=> dtrreq_n); // R3
    AST_TX_HOLDOFF: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_q.req_en && cfg_q.dtr_req_en && dma_wr_tx) |=> dtrreq_n); // R9
    AST_RX_HOLDOFF: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_q.req_en && cfg_q.func_req && cfg_q.dir_rx && dma_rd_rx) |=> wreq_n); // R9
    AST_RX_EMPTY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_q.req_en && cfg_q.func_req && cfg_q.dir_rx && rx_level == '0) |=> wreq_n); // R5
    AST_WAIT_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_q.req_en && !cfg_q.func_req && cpu_rd_rx && rx_level == '0) |=> !wreq_n); // R8
endmodule

// File: tb/sdma_req_top_tb.sv
module sdma_req_top_tb_top;
    localparam int TXD = 4;
    localparam int RXD = 4;
    localparam int TXW = $clog2(TXD + 1);
    localparam int RXW = $clog2(RXD + 1);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_we = 1'b0;
    logic [6:0] cfg_wdata = '0;
    logic [TXW-1:0] tx_level = '0;
    logic [RXW-1:0] rx_level = '0;
    logic cpu_rd_rx = 1'b0, dma_wr_tx = 1'b0, dma_rd_rx = 1'b0;
    logic wreq_n, dtrreq_n, tx_mode_o;

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    bit done = 1'b0;
    bit live = 1'b0;
    string tag = "R1";

    // reference model state
    logic [6:0] m_cfg;
    logic e_w, e_d, e_m;

    always #4 clk = ~clk;

    sdma_req_top #(.TX_DEPTH(TXD), .RX_DEPTH(RXD)) dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .tx_level(tx_level), .rx_level(rx_level), .cpu_rd_rx(cpu_rd_rx),
        .dma_wr_tx(dma_wr_tx), .dma_rd_rx(dma_rd_rx),
        .wreq_n(wreq_n), .dtrreq_n(dtrreq_n), .tx_mode_o(tx_mode_o)
    );

    always @(posedge clk) begin
        bit en, reqm, dirrx, dtren, dbit, pace, txok, rxok, stall;
        if (!rst_n) begin
            m_cfg <= 7'h20; e_w <= 1; e_d <= 1; e_m <= 1;
        end else begin
            en = m_cfg[0]; reqm = m_cfg[1]; dirrx = m_cfg[2];
            dtren = m_cfg[3]; dbit = m_cfg[4]; pace = m_cfg[5];
            if (pace) txok = (int'(tx_level) == 0);
            else      txok = (int'(tx_level) < TXD);
            if (dma_wr_tx) txok = 0;
            rxok  = (int'(rx_level) > 0) && !dma_rd_rx;
            stall = cpu_rd_rx && (int'(rx_level) == 0);
            if (!en)        e_w <= 1;
            else if (reqm)  e_w <= dirrx ? !rxok : !txok;
            else            e_w <= !stall;
            e_d <= (en && dtren) ? !txok : !dbit;
            if (cfg_we) begin
                m_cfg <= cfg_wdata; e_m <= cfg_wdata[5];
            end else e_m <= pace;
        end
    end

    task automatic chk(input string t, input string nm, input logic a, input logic e);
        checks++;
        if (a !== e) begin
            failures++;
            $display("FAIL %s %s actual=%b expected=%b t=%0t", t, nm, a, e, $time);
        end
    endtask

    always @(negedge clk) begin
        if (live && rst_n) begin
            chk(tag, "wreq_n", wreq_n, e_w);
            chk(tag, "dtrreq_n", dtrreq_n, e_d);
            chk(tag, "tx_mode_o", tx_mode_o, e_m);
        end
    end

    task automatic step(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wcfg(input logic [6:0] v);
        cfg_we = 1; cfg_wdata = v;
        step(1);
        cfg_we = 0;
        step(1);
    endtask

    task automatic sweep(input int n, input bit strobes, input bit rdcpu);
        for (int i = 0; i < n; i++) begin
            tx_level  = TXW'($urandom_range(0, TXD));
            rx_level  = RXW'($urandom_range(0, RXD));
            dma_wr_tx = strobes ? 1'($urandom_range(0, 1)) : 1'b0;
            dma_rd_rx = strobes ? 1'($urandom_range(0, 1)) : 1'b0;
            cpu_rd_rx = rdcpu ? 1'($urandom_range(0, 1)) : 1'b0;
            step(1);
        end
        dma_wr_tx = 0; dma_rd_rx = 0; cpu_rd_rx = 0;
    endtask

    initial begin
        step(3);
        // R1: reset values seen before release
        chk("R1", "wreq_n", wreq_n, 1'b1);
        chk("R1", "dtrreq_n", dtrreq_n, 1'b1);
        chk("R1", "tx_mode_o", tx_mode_o, 1'b1);
        rst_n = 1; live = 1;
        tag = "R1"; sweep(10, 1, 1);
        tag = "R10"; wcfg(7'b001_0000); sweep(20, 1, 1);     // disabled, modem bit set
        tag = "R2";  wcfg(7'b000_0000); step(3);
        tag = "R3";  wcfg(7'b000_1001);                       // pacing 0, pin2 tx req
        for (int l = 0; l <= TXD; l++) begin tx_level = TXW'(l); step(2); end
        sweep(30, 0, 0);
        tag = "R4";  wcfg(7'b010_1001);
        for (int l = TXD; l >= 0; l--) begin tx_level = TXW'(l); step(2); end
        sweep(30, 0, 0);
        tag = "R5";  wcfg(7'b100_0111); sweep(30, 0, 0);      // rx req, threshold set
        wcfg(7'b000_0111); sweep(30, 0, 0);
        tag = "R6";  wcfg(7'b000_0011); sweep(30, 0, 0);
        tag = "R7";  wcfg(7'b000_1111); sweep(30, 0, 0);      // full duplex
        tag = "R8";  wcfg(7'b000_0001);
        rx_level = '0; cpu_rd_rx = 1; step(5);
        rx_level = RXW'(2); step(2); cpu_rd_rx = 0;
        sweep(40, 1, 1);
        tag = "R9";  wcfg(7'b000_1111);
        tx_level = '0; rx_level = RXW'(3);
        for (int i = 0; i < 6; i++) begin
            dma_wr_tx = 1; dma_rd_rx = 1; step(1);
            dma_wr_tx = 0; dma_rd_rx = 0; step(1);
        end
        sweep(40, 1, 0);
        tag = "R10"; wcfg(7'b000_0101); sweep(20, 1, 1);     // enabled, pin2 modem low
        tag = "R11";
        for (int k = 0; k < 8; k++) begin
            wcfg(7'($urandom_range(0, 127)));
            sweep(25, 1, 1);
        end
        live = 0;
        done = 1;
    end

    initial begin
        while (!done && cycles < 100000) begin
            @(posedge clk); cycles++;
        end
        if (!done) begin
            checks++; failures++;
            $display("FAIL watchdog actual=hung expected=done");
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule